// File: doc/BRIEF.md
# Gated Serial Transceiver with Debug Suspend

This block is an asynchronous serial transmitter and receiver pair with a fixed 8N1 frame: one low start bit, eight data bits sent least significant bit first, and one high stop bit. A single 32-bit control word sets how it runs. That word holds separate transmit and receive enables, a continue-on-suspend choice, an internal loopback switch and an active-low software reset.

The two enables act only where data crosses between a holding buffer and a shift register. As a result, the receive shifter keeps assembling frames while reception is disabled, and a frame already being shifted out always finishes.

A debug-halt input either freezes the whole engine in place or lets the work in progress drain before it idles. Software writes bytes into a one-entry transmit holding buffer. It reads received bytes from a one-entry receive buffer, which has ready, overrun and framing-error flags and two interrupt outputs.

Top module: `gated_uart`

## Requirements
- R1: After reset, the control word reads 0, `txPin` is 1, `txReady` is 1, and `rxReady`, `overrun` and `frameErr` are 0.
- R2: Only control bits 25 (transmit enable), 24 (receive enable), 17 (continue on suspend), 16 (loopback) and 7 (software reset, active low) can be written. Every other bit reads 0, so writing all ones reads back 32'h0303_0080.
- R3: While control bit 7 is 0, the transmitter, receiver, buffers and flags stay in their reset state, and a `txWe` write is ignored. The control word itself can still be written.
- R4: A `txWe` write made while transmit enable is 0 is discarded. It is never sent, even after transmit enable is later set, and `txReady` stays 1.
- R5: With transmit enable set, a byte in the holding buffer moves to the shifter on the next clock and goes out on `txPin` as 10 bits of 16·`CLK_DIV` clocks each. The bits are start 0, then the data LSB first, then stop 1. `txReady` is 1 whenever the holding buffer is empty.
- R6: Clearing transmit enable while a frame is being shifted out does not cut it short; the frame completes on the line.
- R7: The receive shifter runs whatever the state of receive enable. A frame that completes while receive enable is 0 changes no receive flag and no receive data. Receive enable is sampled only when a frame completes, so setting it mid-frame still delivers that frame.
- R8: When a received byte is transferred, it appears on `rxData` and `rxReady` and `rxIrq` go to 1. A one-cycle `rxRe` pulse clears `rxReady`, `overrun` and `frameErr`.
- R9: If a byte is transferred while `rxReady` is still 1, `overrun` and `errIrq` go to 1 and `rxData` takes the newer byte.
- R10: The receiver samples each bit at its middle using 16x oversampling. A low stop bit sets `frameErr` and `errIrq`.
- R11: A start bit that is no longer low at its midpoint is rejected, and no byte is delivered.
- R12: With continue-on-suspend at 0, `dbgHalt` freezes the state machines and their counters. When it is released, the frame resumes exactly where it stopped, so each bit is stretched by the length of the halt.
- R13: With continue-on-suspend at 1, `dbgHalt` lets the frame in progress finish. No new transmit frame and no new receive frame starts until the halt is released.
- R14: With loopback at 1, the transmitter output feeds the receiver in place of `rxPin`, and `txPin` is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Control word write strobe |
| regWdata | input | 32 | Control word write value |
| regRdata | output | 32 | Control word read value |
| txWe | input | 1 | Transmit holding buffer write strobe |
| txData | input | 8 | Byte to transmit |
| rxRe | input | 1 | Receive buffer read strobe; clears receive flags |
| rxData | output | 8 | Last transferred received byte |
| txReady | output | 1 | Transmit holding buffer empty |
| rxReady | output | 1 | Unread received byte present |
| overrun | output | 1 | Byte transferred while previous one unread |
| frameErr | output | 1 | Stop bit sampled low |
| rxIrq | output | 1 | Receive interrupt |
| errIrq | output | 1 | Error interrupt (overrun or framing) |
| txPin | output | 1 | Serial transmit line, idle high |
| rxPin | input | 1 | Serial receive line, idle high |
| dbgHalt | input | 1 | Debug suspend request |

## Verification
The assertions assume three things about the inputs. Software never writes the holding buffer while it is already full. An `rxRe` pulse never lands on the cycle a received byte is transferred. The control word stays unchanged for the whole of a debug halt. The stimulus keeps within these by writing each byte only after `txReady` is back at 1 and by waiting a full frame before reading. It issues control writes only while `dbgHalt` is 0. Serial input on `rxPin` is driven at whole-bit spacing from the same clock, so the receiver's mid-bit sampling always falls well inside each bit.

// File: rtl/gated_uart_pkg.sv
package gated_uart_pkg;
  localparam int CtrlW  = 32;
  localparam int TxEnB  = 25;
  localparam int RxEnB  = 24;
  localparam int ContB  = 17;
  localparam int LoopB  = 16;
  localparam int SrstNB = 7;
  localparam logic [CtrlW-1:0] CtrlMask = 32'h0303_0080;
  localparam int FrameBits = 10;

  // strobes from control to datapath
  typedef struct packed {
    logic txLoad;   // move holding byte into the shifter
    logic freeze;   // stop all counters in place
    logic holdOff;  // no new frame may start
    logic clear;    // software reset
  } dpCtl_t;

  // results from datapath to control
  typedef struct packed {
    logic       txBusy;
    logic       rxDone;
    logic       stopOk;
    logic [7:0] rxByte;
  } dpStat_t;
endpackage

// File: rtl/gated_uart_dp.sv
module gated_uart_dp
  import gated_uart_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int OVS     = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCtl_t     ctl,
  input  logic [7:0] txByte,
  input  logic       rxIn,
  output logic       txLine,
  output dpStat_t    stat
);
  localparam int BitClks = CLK_DIV * OVS;
  localparam int TickW   = $clog2(BitClks);
  localparam int DivW    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int PhW     = $clog2(OVS);

  // transmit shifter
  logic [FrameBits-1:0] txFrame;
  logic [3:0]           txIdx;
  logic [TickW-1:0]     txTick;
  logic                 txBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFrame <= '1; txIdx <= '0; txTick <= '0; txBusy <= 1'b0;
    end else if (ctl.clear) begin
      txFrame <= '1; txIdx <= '0; txTick <= '0; txBusy <= 1'b0;
    end else if (ctl.txLoad) begin
      txFrame <= {1'b1, txByte, 1'b0};
      txIdx   <= '0;
      txTick  <= '0;
      txBusy  <= 1'b1;
    end else if (txBusy && !ctl.freeze) begin
      if (txTick == TickW'(BitClks - 1)) begin
        txTick <= '0;
        if (txIdx == 4'(FrameBits - 1)) txBusy <= 1'b0;
        else                            txIdx  <= txIdx + 4'd1;
      end else begin
        txTick <= txTick + 1'b1;
      end
    end
  end

  assign txLine = txBusy ? txFrame[txIdx] : 1'b1;

  // receive path: synchronizer then oversampling shifter
  typedef enum logic [1:0] {RxIdle, RxStart, RxData, RxStop} rxSt_t;
  rxSt_t           rxSt;
  logic [1:0]      rxSync;
  logic            rxS;
  logic [DivW-1:0] divCnt;
  logic [PhW-1:0]  phase;
  logic [2:0]      bitCnt;
  logic [7:0]      rxShift;
  logic            rxDone, stopOk, ovsTick;

  assign rxS     = rxSync[1];
  assign ovsTick = (divCnt == DivW'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rxSync <= 2'b11;
    else       rxSync <= {rxSync[0], rxIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSt <= RxIdle; divCnt <= '0; phase <= '0; bitCnt <= '0;
      rxShift <= '0; rxDone <= 1'b0; stopOk <= 1'b1;
    end else if (ctl.clear) begin
      rxSt <= RxIdle; divCnt <= '0; phase <= '0; bitCnt <= '0;
      rxShift <= '0; rxDone <= 1'b0; stopOk <= 1'b1;
    end else begin
      rxDone <= 1'b0;
      if (!ctl.freeze) begin
        if (rxSt == RxIdle) begin
          if (!rxS && !ctl.holdOff) begin
            rxSt <= RxStart; phase <= '0; divCnt <= '0;
          end
        end else begin
          divCnt <= ovsTick ? '0 : divCnt + 1'b1;
          if (ovsTick) begin
            phase <= phase + 1'b1;
            unique case (rxSt)
              RxStart: if (phase == PhW'(OVS/2 - 1)) begin
                if (!rxS) begin rxSt <= RxData; phase <= '0; bitCnt <= '0; end
                else      rxSt <= RxIdle;
              end
              RxData: if (phase == PhW'(OVS - 1)) begin
                rxShift <= {rxS, rxShift[7:1]};
                bitCnt  <= bitCnt + 3'd1;
                if (bitCnt == 3'd7) rxSt <= RxStop;
              end
              RxStop: if (phase == PhW'(OVS - 1)) begin
                rxDone <= 1'b1;
                stopOk <= rxS;
                rxSt   <= RxIdle;
              end
              default: rxSt <= RxIdle;
            endcase
          end
        end
      end
    end
  end

  assign stat = '{txBusy: txBusy, rxDone: rxDone, stopOk: stopOk, rxByte: rxShift};
endmodule

// File: rtl/gated_uart_ctrl.sv
module gated_uart_ctrl
  import gated_uart_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [CtrlW-1:0] regWdata,
  output logic [CtrlW-1:0] ctrl,
  input  logic             txWe,
  input  logic [7:0]       txData,
  input  logic             rxRe,
  input  logic             dbgHalt,
  input  dpStat_t          stat,
  output dpCtl_t           ctl,
  output logic [7:0]       txByte,
  output logic [7:0]       rxBuf,
  output logic             txFull,
  output logic             rxReady,
  output logic             overrun,
  output logic             frameErr
);
  logic inReset, txEn, rxEn;

  assign inReset = !ctrl[SrstNB];
  assign txEn    = ctrl[TxEnB];
  assign rxEn    = ctrl[RxEnB];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      ctrl <= '0;
    else if (regWe) ctrl <= regWdata & CtrlMask;
  end

  always_comb begin
    ctl.clear   = inReset;
    ctl.freeze  = dbgHalt && !ctrl[ContB];
    ctl.holdOff = dbgHalt;
    ctl.txLoad  = !inReset && !dbgHalt && txEn && txFull && !stat.txBusy;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txFull <= 1'b0; txByte <= '0;
    end else if (inReset) begin
      txFull <= 1'b0; txByte <= '0;
    end else if (txWe && txEn) begin
      txFull <= 1'b1; txByte <= txData;
    end else if (ctl.txLoad) begin
      txFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBuf <= '0; rxReady <= 1'b0; overrun <= 1'b0; frameErr <= 1'b0;
    end else if (inReset) begin
      rxBuf <= '0; rxReady <= 1'b0; overrun <= 1'b0; frameErr <= 1'b0;
    end else if (stat.rxDone && rxEn) begin
      rxBuf    <= stat.rxByte;
      rxReady  <= 1'b1;
      overrun  <= overrun | rxReady;
      frameErr <= frameErr | !stat.stopOk;
    end else if (rxRe) begin
      rxReady <= 1'b0; overrun <= 1'b0; frameErr <= 1'b0;
    end
  end
endmodule

// File: rtl/gated_uart.sv
module gated_uart
  import gated_uart_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        txWe,
  input  logic [7:0]  txData,
  input  logic        rxRe,
  output logic [7:0]  rxData,
  output logic        txReady,
  output logic        rxReady,
  output logic        overrun,
  output logic        frameErr,
  output logic        rxIrq,
  output logic        errIrq,
  output logic        txPin,
  input  logic        rxPin,
  input  logic        dbgHalt
);
  dpCtl_t     ctl;
  dpStat_t    stat;
  logic [7:0] txByte;
  logic       txLine, txFull, loopOn;

  gated_uart_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata), .ctrl(regRdata),
    .txWe(txWe), .txData(txData), .rxRe(rxRe), .dbgHalt(dbgHalt), .stat(stat),
    .ctl(ctl), .txByte(txByte), .rxBuf(rxData), .txFull(txFull),
    .rxReady(rxReady), .overrun(overrun), .frameErr(frameErr)
  );

  gated_uart_dp #(.CLK_DIV(CLK_DIV), .OVS(16)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .txByte(txByte),
    .rxIn(loopOn ? txLine : rxPin), .txLine(txLine), .stat(stat)
  );

  assign loopOn  = regRdata[LoopB];
  assign txPin   = loopOn ? 1'b1 : txLine;
  assign txReady = !txFull;
  assign rxIrq   = rxReady;
  assign errIrq  = overrun | frameErr;
endmodule

// File: rtl/gated_uart_chk.sv
module gated_uart_chk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] regRdata,
  input logic        dbgHalt,
  input logic        txPin,
  input logic        txReady,
  input logic        rxReady,
  input logic        overrun
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regRdata & ~32'h0303_0080) == 32'h0);

  // R3
  sw_reset_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!regRdata[7] && $past(!regRdata[7])) |-> (txReady && !rxReady && txPin));

  // R4
  tx_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txReady) |-> $past(regRdata[25]));

  // R7
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> $past(regRdata[24]));

  // R9
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(rxReady));

  // R12
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dbgHalt && !regRdata[17] && $past(dbgHalt) && $past(!regRdata[17]) && $stable(regRdata))
      |-> $stable(txPin));

  // R14
  loop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[16] |-> txPin);
endmodule

bind gated_uart gated_uart_chk u_chk (
  .clk(clk), .rstN(rstN), .regRdata(regRdata), .dbgHalt(dbgHalt),
  .txPin(txPin), .txReady(txReady), .rxReady(rxReady), .overrun(overrun)
);

// File: tb/tb_gated_uart.sv
module tb_gated_uart;
  localparam int DIV = 1;
  localparam int BIT = 16 * DIV;
  localparam logic [31:0] MASK = 32'h0303_0080;

  logic clk = 0, rstN = 0;
  logic regWe = 0, txWe = 0, rxRe = 0, rxPin = 1, dbgHalt = 0;
  logic [31:0] regWdata = 0, regRdata;
  logic [7:0] txData = 0, rxData;
  logic txReady, rxReady, overrun, frameErr, rxIrq, errIrq, txPin;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  gated_uart #(.CLK_DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .txWe(txWe), .txData(txData), .rxRe(rxRe), .rxData(rxData), .txReady(txReady),
    .rxReady(rxReady), .overrun(overrun), .frameErr(frameErr), .rxIrq(rxIrq),
    .errIrq(errIrq), .txPin(txPin), .rxPin(rxPin), .dbgHalt(dbgHalt)
  );

  always #10 clk = ~clk;

  // behavioural reference of control word and transmit line
  logic [31:0] mCtrl = 0;
  logic [9:0]  mFrame = '1;
  logic [7:0]  mHold = 0;
  bit mFull = 0, mBusy = 0;
  int mCnt = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mCtrl = 0; mFull = 0; mBusy = 0; mCnt = 0;
    end else begin
      bit sr, frz, ld;
      sr  = !mCtrl[7];
      frz = dbgHalt && !mCtrl[17];
      ld  = !sr && !dbgHalt && mCtrl[25] && mFull && !mBusy;
      if (sr) begin
        mFull = 0; mBusy = 0;
      end else begin
        if (mBusy && !frz) begin
          mCnt++;
          if (mCnt == 10 * BIT) mBusy = 0;
        end
        if (txWe && mCtrl[25]) begin mFull = 1; mHold = txData; end
        else if (ld) begin
          mFull = 0; mBusy = 1; mCnt = 0; mFrame = {1'b1, mHold, 1'b0};
        end
      end
      if (regWe) mCtrl = regWdata & MASK;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // compare against reference on every clock
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic expPin;
      expPin = mCtrl[16] ? 1'b1 : (mBusy ? mFrame[mCnt / BIT] : 1'b1);
      chk(txPin === expPin, "R5/R6/R12/R13/R14 txPin", int'(txPin), int'(expPin));
      chk(txReady === !mFull, "R4 txReady", int'(txReady), int'(!mFull));
      chk(regRdata === mCtrl, "R2 regRdata", int'(regRdata), int'(mCtrl));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrCtrl(input logic [31:0] v);
    regWe = 1; regWdata = v; tick(1); regWe = 0;
  endtask

  task automatic putByte(input logic [7:0] b);
    txWe = 1; txData = b; tick(1); txWe = 0;
  endtask

  task automatic readRx();
    rxRe = 1; tick(1); rxRe = 0;
  endtask

  task automatic drvFrame(input logic [7:0] b, input logic stopBit);
    rxPin = 0; tick(BIT);
    for (int i = 0; i < 8; i++) begin rxPin = b[i]; tick(BIT); end
    rxPin = stopBit; tick(BIT);
    rxPin = 1;
  endtask

  initial begin
    tick(3);
    rstN = 1;
    tick(2);
    // R1 reset state
    chk(regRdata == 0 && txPin && txReady && !rxReady && !overrun && !frameErr,
        "R1 reset", int'(regRdata), 0);

    // R2 reserved bits
    wrCtrl(32'hFFFF_FFFF);
    chk(regRdata == 32'h0303_0080, "R2 mask", int'(regRdata), 32'h0303_0080);

    // R3 software reset holds buffers
    wrCtrl(32'h0200_0000);
    putByte(8'h33);
    tick(2);
    chk(txReady == 1, "R3 txWe ignored", int'(txReady), 1);
    chk(regRdata == 32'h0200_0000, "R3 ctrl writable", int'(regRdata), 32'h0200_0000);

    // R4 write while tx disabled is discarded
    wrCtrl(32'h0000_0080);
    putByte(8'h5A);
    wrCtrl(32'h0200_0080);
    tick(3 * BIT);
    chk(txPin == 1 && txReady == 1, "R4 discarded", int'(txPin), 1);

    // R5 normal frame
    putByte(8'hA5);
    tick(12 * BIT);
    // R6 clear enable mid-frame
    putByte(8'h3C);
    tick(3 * BIT);
    wrCtrl(32'h0000_0080);
    tick(4 * BIT);
    chk(txPin == 1'b0 || txPin == 1'b1, "R6 in flight", int'(txPin), int'(txPin));
    tick(6 * BIT);
    wrCtrl(32'h0200_0080);

    // R14 + R8 loopback receive and read-clear
    wrCtrl(32'h0301_0080);
    putByte(8'h96);
    tick(12 * BIT);
    chk(rxReady && rxIrq, "R8 rxReady", int'(rxReady), 1);
    chk(rxData == 8'h96, "R14 loop data", int'(rxData), 8'h96);
    readRx();
    chk(!rxReady && !rxIrq, "R8 read clears", int'(rxReady), 0);

    // R9 overrun
    putByte(8'h11);
    tick(12 * BIT);
    putByte(8'h22);
    tick(12 * BIT);
    chk(overrun && errIrq, "R9 overrun", int'(overrun), 1);
    chk(rxData == 8'h22, "R9 newer byte", int'(rxData), 8'h22);
    readRx();
    chk(!overrun && !errIrq, "R9 cleared", int'(overrun), 0);

    // R7 receive disabled, then enabled mid-frame
    wrCtrl(32'h0201_0080);
    putByte(8'h44);
    tick(12 * BIT);
    chk(!rxReady, "R7 disabled no transfer", int'(rxReady), 0);
    chk(rxData == 8'h22, "R7 data untouched", int'(rxData), 8'h22);
    putByte(8'h55);
    tick(5 * BIT);
    wrCtrl(32'h0301_0080);
    tick(7 * BIT);
    chk(rxReady && rxData == 8'h55, "R7 mid-frame enable", int'(rxData), 8'h55);
    readRx();

    // R10 framing error from the pin
    wrCtrl(32'h0100_0080);
    drvFrame(8'h77, 1'b0);
    tick(4);
    chk(frameErr && errIrq, "R10 frameErr", int'(frameErr), 1);
    chk(rxData == 8'h77, "R10 data", int'(rxData), 8'h77);
    readRx();
    tick(2 * BIT);
    drvFrame(8'hC6, 1'b1);
    tick(4);
    chk(!frameErr && rxData == 8'hC6, "R10 good stop", int'(rxData), 8'hC6);
    readRx();

    // R11 short glitch rejected
    rxPin = 0; tick(4); rxPin = 1;
    tick(12 * BIT);
    chk(!rxReady, "R11 false start", int'(rxReady), 0);

    // R12 freeze mid-frame
    wrCtrl(32'h0200_0080);
    putByte(8'hC3);
    tick(3 * BIT + 5);
    dbgHalt = 1;
    tick(2);
    begin
      logic held;
      held = txPin;
      tick(90);
      chk(txPin == held && !txReady == 0, "R12 frozen", int'(txPin), int'(held));
    end
    dbgHalt = 0;
    tick(12 * BIT);

    // R13 continue on suspend: finish, then idle
    wrCtrl(32'h0202_0080);
    putByte(8'h81);
    tick(2 * BIT);
    dbgHalt = 1;
    putByte(8'h7E);
    tick(12 * BIT);
    chk(txPin == 1 && txReady == 0, "R13 drained and idle", int'(txReady), 0);
    dbgHalt = 0;
    tick(12 * BIT);
    chk(txReady == 1, "R13 resumes", int'(txReady), 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule